// File: doc/BRIEF.md
# Multi-Cycle Array Coprocessor Controller

This controller sits between a processor and a reconfigurable coprocessor array. The processor selects an array configuration by a short name. The controller keeps a small cache of recently used names. A name found in the cache becomes resident at once. A name that is missing is fetched through a load request and acknowledge handshake toward configuration memory. The processor is stalled until that acknowledge arrives.

The processor then writes two operands. Once both operands are held and a configuration is resident, the controller starts a multi-cycle operation. A cycle counter, loaded at the start, tracks the remaining cycles, and the processor is stalled for the whole run. The array is a placeholder datapath that keeps an accumulator between cycles. After the run, one result read returns the value. A read issued while the run is still going is remembered, and the stall is held until the result is delivered. A configure command that arrives during a run is refused and flagged.

Top module: `arrcop_ctrl`

## Requirements
- R1: After reset, `stall`, `ld_req`, `rd_valid` and `cfg_err` are all 0.
- R2: `cmd_op` encodes 0 = configure, 1 = write operand A, 2 = write operand B, 3 = read result. A command is taken only when `cmd_valid` is 1 and `stall` is 0. A configure whose name is cached raises no `ld_req` and leaves `stall` at 0.
- R3: A configure whose name is not cached raises `ld_req` with `ld_id` equal to the name in the next cycle. `stall` stays 1 until the cycle in which `ld_ack` is 1. After that cycle `ld_req` is 0 and the name is resident.
- R4: The cache holds NWAY (default 4) names with least-recently-used replacement. Both a hit and a completed load make a name the most recent. A fill uses an empty entry first; otherwise it evicts the least recent name.
- R5: An operation starts only when both operands have been written since the last operation and a configuration is resident. Without a resident configuration, the operand writes leave `stall` at 0. The operation begins automatically once a load completes.
- R6: `stall` is 1 for exactly LAT+1 consecutive cycles, beginning the cycle after the second operand is captured (or after the load completes). The value read afterwards is A + LAT*(B + name), modulo 2^W.
- R7: A read presented while the operation runs keeps `stall` at 1 through the result-ready cycle. `rd_valid` is then 1 for exactly one cycle with the result, and `stall` falls in that same cycle.
- R8: A configure presented during a run makes `cfg_err` 1 for one cycle, in the next cycle. It raises no `ld_req` and does not change the resident configuration or the cache order.
- R9: A read presented when no result is waiting produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_id | input | ID_W | Configuration name for configure |
| cmd_data | input | W | Operand value for writes |
| stall | output | 1 | Processor must hold its command |
| rd_valid | output | 1 | Result valid, one cycle |
| rd_data | output | W | Result value |
| cfg_err | output | 1 | Configure refused during a run |
| ld_req | output | 1 | Configuration load request |
| ld_id | output | ID_W | Name to load |
| ld_ack | input | 1 | Load complete |

## Verification
The bench builds the block with W=16, ID_W=3, NWAY=4 and LAT=5. Eight possible names against four cache entries make evictions frequent under random configure sequences. A bench LRU list predicts every hit and miss. The short run length lets many operations of each read style fit in the run, and it puts an injected configure well inside the run window.

// File: rtl/arrcop_pkg.sv
package arrcop_pkg;

  typedef enum logic [1:0] {
    OP_CFG = 2'd0,
    OP_WRA = 2'd1,
    OP_WRB = 2'd2,
    OP_RD  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } st_e;

endpackage

// File: rtl/arrcop_cache.sv
module arrcop_cache #(
  parameter int NWAY = 4,
  parameter int ID_W = 3,
  localparam int AW = (NWAY > 1) ? $clog2(NWAY) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] lk_id,
  output logic            hit,
  output logic [AW-1:0]   hit_way,
  input  logic            touch_en,
  input  logic [AW-1:0]   touch_way,
  input  logic            inst_en,
  input  logic [ID_W-1:0] inst_id
);

  logic [ID_W-1:0] tag_q [NWAY];
  logic [AW-1:0]   age_q [NWAY];
  logic [NWAY-1:0] vld_q;
  logic [NWAY-1:0] hit_vec;
  logic [NWAY-1:0] old_vec;
  logic [AW-1:0]   victim;
  logic [AW-1:0]   upd_way;
  logic            upd_en;

  for (genvar g = 0; g < NWAY; g++) begin : g_way
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_id);
    assign old_vec[g] = (age_q[g] == AW'(NWAY - 1));
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < NWAY; i++)
      if (hit_vec[i]) hit_way = AW'(i);
  end

  // first empty entry, otherwise the oldest
  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < NWAY; i++)
      if (!vld_q[i] && !found) begin
        victim = AW'(i);
        found  = 1'b1;
      end
    if (!found)
      for (int i = 0; i < NWAY; i++)
        if (old_vec[i]) victim = AW'(i);
  end

  assign upd_en  = inst_en | touch_en;
  assign upd_way = inst_en ? victim : touch_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NWAY; i++) begin
        tag_q[i] <= '0;
        age_q[i] <= AW'(i);
      end
    end else begin
      if (inst_en) begin
        tag_q[victim] <= inst_id;
        vld_q[victim] <= 1'b1;
      end
      if (upd_en)
        for (int i = 0; i < NWAY; i++) begin
          if (AW'(i) == upd_way)
            age_q[i] <= '0;
          else if (age_q[i] < age_q[upd_way])
            age_q[i] <= age_q[i] + 1'b1;
        end
    end
  end

  // R4: ages stay a permutation, so exactly one entry is the oldest
  a_r4_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(old_vec) == 1);

  // R2: a name is never cached in two entries
  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/arrcop_opcnt.sv
module arrcop_opcnt #(
  parameter int LAT = 5,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic last
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= CW'(LAT);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CW'(1));

  // R6: a start fills the counter with the full run length
  a_r6_load_full: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == CW'(LAT)));

  // R6: the run counts down one per cycle
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/arrcop_array.sv
module arrcop_array #(
  parameter int W    = 16,
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            step_en,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [ID_W-1:0] cfg,
  output logic [W-1:0]    acc
);

  logic [W-1:0]    b_q;
  logic [ID_W-1:0] cfg_q;

  function automatic logic [W-1:0] arr_step(input logic [W-1:0] a_in,
                                            input logic [W-1:0] b_in,
                                            input logic [ID_W-1:0] c_in);
    return a_in + b_in + W'(c_in);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      b_q   <= '0;
      cfg_q <= '0;
    end else if (start) begin
      acc   <= opa;
      b_q   <= opb;
      cfg_q <= cfg;
    end else if (step_en) begin
      acc <= arr_step(acc, b_q, cfg_q);
    end
  end

endmodule

// File: rtl/arrcop_ctrl.sv
module arrcop_ctrl #(
  parameter int W    = 16,
  parameter int ID_W = 3,
  parameter int NWAY = 4,
  parameter int LAT  = 5,
  localparam int AW = (NWAY > 1) ? $clog2(NWAY) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [ID_W-1:0] cmd_id,
  input  logic [W-1:0]    cmd_data,
  output logic            stall,
  output logic            rd_valid,
  output logic [W-1:0]    rd_data,
  output logic            cfg_err,
  output logic            ld_req,
  output logic [ID_W-1:0] ld_id,
  input  logic            ld_ack
);
  import arrcop_pkg::*;

  st_e             st_q;
  logic [W-1:0]    opa_q, opb_q;
  logic            ha_q, hb_q, pend_q, res_ok_q;
  logic [ID_W-1:0] res_id_q, ld_id_q;

  logic            c_hit;
  logic [AW-1:0]   c_way;
  logic            start_op, accept, is_cfg, is_rd;
  logic            touch_en, inst_en;
  logic            op_busy, op_last;
  logic [W-1:0]    acc;

  assign is_cfg   = cmd_valid && (cmd_e'(cmd_op) == OP_CFG);
  assign is_rd    = cmd_valid && (cmd_e'(cmd_op) == OP_RD);
  assign start_op = (st_q == ST_IDLE) && ha_q && hb_q && res_ok_q;
  assign stall    = (st_q == ST_LOAD) || (st_q == ST_RUN) ||
                    ((st_q == ST_DONE) && pend_q) || start_op;
  assign accept   = (st_q == ST_IDLE) && cmd_valid && !stall;
  assign touch_en = accept && is_cfg && c_hit;
  assign inst_en  = (st_q == ST_LOAD) && ld_ack;
  assign ld_req   = (st_q == ST_LOAD);
  assign ld_id    = ld_id_q;

  arrcop_cache #(.NWAY(NWAY), .ID_W(ID_W)) u_cache (
    .clk(clk), .rst_n(rst_n), .lk_id(cmd_id), .hit(c_hit), .hit_way(c_way),
    .touch_en(touch_en), .touch_way(c_way), .inst_en(inst_en), .inst_id(ld_id_q)
  );

  arrcop_opcnt #(.LAT(LAT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(start_op), .busy(op_busy), .last(op_last)
  );

  arrcop_array #(.W(W), .ID_W(ID_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .start(start_op), .step_en(op_busy),
    .opa(opa_q), .opb(opb_q), .cfg(res_id_q), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      opa_q    <= '0;
      opb_q    <= '0;
      ha_q     <= 1'b0;
      hb_q     <= 1'b0;
      pend_q   <= 1'b0;
      res_ok_q <= 1'b0;
      res_id_q <= '0;
      ld_id_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      cfg_err  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      cfg_err  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_op) begin
            st_q <= ST_RUN;
            ha_q <= 1'b0;
            hb_q <= 1'b0;
          end else if (accept) begin
            unique case (cmd_e'(cmd_op))
              OP_CFG: begin
                if (c_hit) begin
                  res_ok_q <= 1'b1;
                  res_id_q <= cmd_id;
                end else begin
                  ld_id_q <= cmd_id;
                  st_q    <= ST_LOAD;
                end
              end
              OP_WRA: begin
                opa_q <= cmd_data;
                ha_q  <= 1'b1;
              end
              OP_WRB: begin
                opb_q <= cmd_data;
                hb_q  <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        ST_LOAD: begin
          if (ld_ack) begin
            res_ok_q <= 1'b1;
            res_id_q <= ld_id_q;
            st_q     <= ST_IDLE;
          end
        end
        ST_RUN: begin
          if (is_cfg) cfg_err <= 1'b1;
          if (is_rd)  pend_q  <= 1'b1;
          if (op_last) st_q <= ST_DONE;
        end
        ST_DONE: begin
          if (pend_q || is_rd) begin
            rd_valid <= 1'b1;
            rd_data  <= acc;
            pend_q   <= 1'b0;
            st_q     <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3: a pending load always holds the processor
  a_r3_load_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |-> stall);

  // R3: the acknowledge ends the request
  a_r3_ack_ends_req: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && ld_ack) |=> !ld_req);

  // R8: a refused configure never starts a load
  a_r8_err_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !ld_req);

  // R7: the result strobe lasts one cycle
  a_r7_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R5: the counter only becomes busy after a legal start
  a_r5_start_legal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_busy) |-> $past(start_op));

  // R7: the result is delivered with the processor released
  a_r7_rd_unstalled: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !stall);

endmodule

// File: tb/sim_arrcop_ctrl.sv
module sim_arrcop_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16, ID_W = 3, NWAY = 4, LAT = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, ld_ack = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [ID_W-1:0] cmd_id = '0;
  logic [W-1:0] cmd_data = '0;
  logic stall, rd_valid, cfg_err, ld_req;
  logic [W-1:0] rd_data;
  logic [ID_W-1:0] ld_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  arrcop_ctrl #(.W(W), .ID_W(ID_W), .NWAY(NWAY), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_id(cmd_id), .cmd_data(cmd_data), .stall(stall), .rd_valid(rd_valid),
    .rd_data(rd_data), .cfg_err(cfg_err), .ld_req(ld_req), .ld_id(ld_id),
    .ld_ack(ld_ack)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  int lru_ids [NWAY];
  int lru_n = 0;
  logic [ID_W-1:0] res_id = '0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_result(input logic [W-1:0] a, input logic [W-1:0] b,
                                              input logic [ID_W-1:0] id);
    logic [W-1:0] per;
    per = b + W'(id);
    return a + W'(LAT) * per;
  endfunction

  function automatic int lru_find(input int id);
    int pos = -1;
    for (int i = 0; i < lru_n; i++) if (lru_ids[i] == id) pos = i;
    return pos;
  endfunction

  task automatic lru_touch(input int id);
    int pos = lru_find(id);
    if (pos < 0) begin
      if (lru_n < NWAY) lru_n++;
      pos = lru_n - 1;
    end
    for (int i = pos; i > 0; i--) lru_ids[i] = lru_ids[i-1];
    lru_ids[0] = id;
  endtask

  task automatic do_cfg(input logic [ID_W-1:0] id);
    bit miss = (lru_find(int'(id)) < 0);
    int dly = $urandom_range(0, 3);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_id = id;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (miss) begin
      check(ld_req == 1'b1, "R3/R4 load on miss", ld_req, 1);
      check(ld_id == id, "R3 load name", ld_id, id);
      for (int i = 0; i < dly; i++) begin
        check(stall == 1'b1, "R3 stall while loading", stall, 1);
        @(negedge clk);
      end
      ld_ack = 1'b1;
      @(negedge clk);
      ld_ack = 1'b0;
      check(ld_req == 1'b0 && stall == 1'b0, "R3 release after ack", {ld_req, stall}, 0);
    end else begin
      check(ld_req == 1'b0, "R2/R4 no load on hit", ld_req, 0);
      check(stall == 1'b0, "R2 no stall on hit", stall, 0);
    end
    lru_touch(int'(id));
    res_id = id;
  endtask

  // mode 0: read after release, 1: early read, 2: configure injected mid-run
  task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b, input int mode);
    logic [W-1:0] e = exp_result(a, b, res_id);
    int k = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_data = a;
    @(negedge clk);
    cmd_op = 2'd2; cmd_data = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (stall && k < 100) begin
      if (mode == 1 && k == 1) begin cmd_valid = 1'b1; cmd_op = 2'd3; end
      if (mode == 2 && k == 2) begin cmd_valid = 1'b1; cmd_op = 2'd0; cmd_id = res_id + 1'b1; end
      if (mode == 2 && k == 3) begin
        check(cfg_err == 1'b1, "R8 error flag", cfg_err, 1);
        check(ld_req == 1'b0, "R8 no load", ld_req, 0);
        cmd_valid = 1'b0;
      end
      if (mode == 2 && k == 4) check(cfg_err == 1'b0, "R8 error one cycle", cfg_err, 0);
      k++;
      @(negedge clk);
    end
    if (mode == 1) begin
      check(k == LAT + 2, "R7 stall held to result", k, LAT + 2);
      check(rd_valid == 1'b1, "R7 result strobe", rd_valid, 1);
      check(rd_data == e, "R7 result value", rd_data, e);
      cmd_valid = 1'b0;
    end else begin
      check(k == LAT + 1, "R6 stall length", k, LAT + 1);
      check(rd_valid == 1'b0, "R6 no early strobe", rd_valid, 0);
      cmd_valid = 1'b1; cmd_op = 2'd3;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(rd_valid == 1'b1, "R6 result strobe", rd_valid, 1);
      check(rd_data == e, mode == 2 ? "R8 resident unchanged" : "R6 result value", rd_data, e);
    end
    @(negedge clk);
    check(rd_valid == 1'b0, "R7 strobe single cycle", rd_valid, 0);
  endtask

  initial begin
    int k;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(stall == 0 && ld_req == 0 && rd_valid == 0 && cfg_err == 0,
          "R1 reset outputs", {stall, ld_req, rd_valid, cfg_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(stall == 0 && ld_req == 0 && rd_valid == 0 && cfg_err == 0,
          "R1 after reset", {stall, ld_req, rd_valid, cfg_err}, 0);

    // R9: read with nothing waiting
    cmd_valid = 1'b1; cmd_op = 2'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(rd_valid == 1'b0, "R9 idle read ignored", rd_valid, 0);

    // R5: operands without a resident configuration
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_data = 16'd100;
    @(negedge clk);
    cmd_op = 2'd2; cmd_data = 16'd7;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check(stall == 1'b0, "R5 no start without config", stall, 0);
      @(negedge clk);
    end
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_id = 3'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(ld_req == 1'b1 && ld_id == 3'd1, "R3 first load", {ld_req, ld_id}, {1'b1, 3'd1});
    ld_ack = 1'b1;
    @(negedge clk);
    ld_ack = 1'b0;
    check(stall == 1'b1 && ld_req == 1'b0, "R5 start after load", {stall, ld_req}, 2);
    lru_touch(1); res_id = 3'd1;
    k = 0;
    while (stall && k < 100) begin k++; @(negedge clk); end
    check(k == LAT + 1, "R5 run length after load", k, LAT + 1);
    cmd_valid = 1'b1; cmd_op = 2'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(rd_valid == 1'b1 && rd_data == exp_result(16'd100, 16'd7, 3'd1),
          "R5 result", rd_data, exp_result(16'd100, 16'd7, 3'd1));

    // R4: directed replacement order
    do_cfg(3'd2); do_cfg(3'd3); do_cfg(3'd4);
    do_cfg(3'd1); do_cfg(3'd5); do_cfg(3'd2); do_cfg(3'd4);
    do_op(16'hFFF0, 16'h0004, 0);
    do_op(16'd9, 16'd3, 1);
    do_op(16'd1234, 16'd55, 2);
    do_cfg(3'd3);

    // R6: wrap of the result
    do_op(16'hFFFF, 16'hFFFF, 0);

    for (int n = 0; n < 60; n++) begin
      if ($urandom_range(0, 1) == 0)
        do_cfg(3'($urandom_range(0, 7)));
      else
        do_op(16'($urandom), 16'($urandom), $urandom_range(0, 2));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule